// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss. It takes the linear address that missed, whether the access is a read or a write, and whether the processor runs in user or supervisor mode. It then reads the first-level (directory) entry and the second-level (table) entry through a single-outstanding memory request/response port. On a good mapping it sets the table entry's accessed flag, and on a write also its dirty flag, by writing the entry back to memory. The write happens only when a flag really changes. The walker then hands a fill record to the translation cache.

When the mapping is absent at either level, or the access breaks the combined user/supervisor or read/write permission, the walker raises a page-fault strobe instead. With the strobe it gives a 16-bit cause code and latches the offending linear address in a fault-address register. The register keeps that value until the next fault. Exception dispatch and instruction restart belong to the surrounding core.

A miss is offered with `miss_valid` and is taken in any cycle in which `miss_ready` is high. The walker handles one miss at a time. Its result strobe appears in the same cycle in which it is ready for the next miss.

Top module: `xlat_walker`

## Requirements
- R1: After reset `miss_ready` is 1, `mem_req_valid`, `fill_valid` and `fault_valid` are 0, and `fault_addr` is 0.
- R2: The directory entry is read at {base[31:12], la[31:22], 2'b00}. The table entry is read at {directory entry[31:12], la[21:12], 2'b00}. Every request address has bits 1:0 equal to zero.
- R3: A directory entry with bit 0 (present) clear raises a fault with code bit 0 = 0, and the table entry is never read.
- R4: A present directory entry with an absent table entry (bit 0 clear) raises a fault with code bit 0 = 0, and nothing is written to memory.
- R5: The effective user bit (entry bit 2) is the AND of both levels, and so is the effective writable bit (entry bit 1). In user mode, an access to an effectively supervisor-only page, or a write to an effectively read-only page, raises a fault with code bit 0 = 1 and leaves the table entry unchanged. Supervisor accesses never raise protection faults.
- R6: The fault code carries the access direction in bit 1 (1 = write) and the mode in bit 2 (1 = user). Bits 15:3 are 0.
- R7: On a fault, `fault_addr` takes the full 32-bit linear address of the miss. It holds that value through later fills until the next fault.
- R8: A successful walk leaves the table entry with bit 5 (accessed) set, and on a write also bit 6 (dirty) set. The write-back is issued only if one of these bits changes.
- R9: A fill carries the virtual page (la[31:12]), the frame (table entry[31:12]), the effective user and writable bits, and the entry's dirty bit after the walk.
- R10: Each accepted miss yields exactly one one-cycle strobe, either `fill_valid` or `fault_valid`, and never both.
- R11: A memory request stays asserted, with the same address and direction, until its response arrives. No new miss is accepted while a walk is in progress.
- R12: `miss_ready` is high in the cycle in which a result strobe is shown, so a next miss can be accepted in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | A translation miss is offered |
| miss_ready | output | 1 | Walker idle, miss accepted this cycle if offered |
| miss_laddr | input | 32 | Linear address that missed |
| miss_write | input | 1 | 1 = write access, 0 = read |
| miss_user | input | 1 | 1 = user mode, 0 = supervisor |
| dir_base | input | 32 | Directory base; bits 31:12 used |
| mem_req_valid | output | 1 | Memory request, held until response |
| mem_req_write | output | 1 | 1 = write-back of a table entry |
| mem_req_addr | output | 32 | Entry byte address |
| mem_req_wdata | output | 32 | Updated entry for a write-back |
| mem_rsp_valid | input | 1 | Response for the pending request |
| mem_rsp_rdata | input | 32 | Read data of the response |
| fill_valid | output | 1 | One-cycle fill strobe |
| fill_vpn | output | 20 | Virtual page number of the fill |
| fill_pfn | output | 20 | Physical frame number of the fill |
| fill_user | output | 1 | Effective user-accessible bit |
| fill_writable | output | 1 | Effective writable bit |
| fill_dirty | output | 1 | Dirty bit after the walk |
| fault_valid | output | 1 | One-cycle page-fault strobe |
| fault_code | output | 16 | Fault cause code |
| fault_addr | output | 32 | Linear address of the latest fault |

## Verification
The result strobe of one walk and the acceptance of the next miss can fall in the same cycle. The driver keeps misses queued back to back, so each new miss is presented while the previous fill or fault strobe is still high. The monitor checks at that moment that `miss_ready` is high and that the strobe matches the oldest prediction and not the new miss. The memory model also answers with zero latency in some cycles, so a response can meet a freshly raised request. The read-address log and the write-back count show whether each walk touched exactly the entries it should.

// File: rtl/xlat_walker_pkg.sv
package xlat_walker_pkg;
    localparam int LA_W   = 32;
    localparam int OFF_W  = 12;
    localparam int IDX_W  = 10;
    localparam int PFN_W  = LA_W - OFF_W;
    localparam int ENT_SH = 2;
    localparam int EC_W   = 16;

    localparam int BIT_PRESENT = 0;
    localparam int BIT_RW      = 1;
    localparam int BIT_US      = 2;
    localparam int BIT_ACC     = 5;
    localparam int BIT_DIRTY   = 6;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DIR  = 2'd1,
        ST_TBL  = 2'd2,
        ST_UPD  = 2'd3
    } walk_st_e;

    typedef struct packed {
        logic [PFN_W-1:0] frame;
        logic             dirty;
        logic             acc;
        logic             us;
        logic             rw;
        logic             present;
    } ent_t;
endpackage

// File: rtl/xw_entry_decode.sv
module xw_entry_decode
    import xlat_walker_pkg::*;
(
    input  logic [LA_W-1:0] raw,
    input  logic            is_write,
    output ent_t            ent,
    output logic [LA_W-1:0] upd_word,
    output logic            needs_upd
);
    logic [LA_W-1:0] set_mask;

    always_comb begin
        ent.frame   = raw[LA_W-1:OFF_W];
        ent.dirty   = raw[BIT_DIRTY];
        ent.acc     = raw[BIT_ACC];
        ent.us      = raw[BIT_US];
        ent.rw      = raw[BIT_RW];
        ent.present = raw[BIT_PRESENT];

        set_mask             = '0;
        set_mask[BIT_ACC]    = 1'b1;
        set_mask[BIT_DIRTY]  = is_write;
        upd_word             = raw | set_mask;
        needs_upd            = (upd_word != raw);
    end
endmodule

// File: rtl/xw_perm_check.sv
module xw_perm_check
    import xlat_walker_pkg::*;
(
    input  ent_t dir_e,
    input  ent_t tbl_e,
    input  logic is_write,
    input  logic is_user,
    output logic eff_us,
    output logic eff_rw,
    output logic viol
);
    always_comb begin
        eff_us = dir_e.us & tbl_e.us;
        eff_rw = dir_e.rw & tbl_e.rw;
        viol   = is_user & (~eff_us | (is_write & ~eff_rw));
    end
endmodule

// File: rtl/xw_errcode.sv
module xw_errcode
    import xlat_walker_pkg::*;
#(
    parameter int CODE_W = EC_W
) (
    input  logic              prot,
    input  logic              is_write,
    input  logic              is_user,
    output logic [CODE_W-1:0] code
);
    always_comb begin
        code    = '0;
        code[0] = prot;
        code[1] = is_write;
        code[2] = is_user;
    end
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
    import xlat_walker_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             miss_valid,
    output logic             miss_ready,
    input  logic [LA_W-1:0]  miss_laddr,
    input  logic             miss_write,
    input  logic             miss_user,
    input  logic [LA_W-1:0]  dir_base,
    output logic             mem_req_valid,
    output logic             mem_req_write,
    output logic [LA_W-1:0]  mem_req_addr,
    output logic [LA_W-1:0]  mem_req_wdata,
    input  logic             mem_rsp_valid,
    input  logic [LA_W-1:0]  mem_rsp_rdata,
    output logic             fill_valid,
    output logic [PFN_W-1:0] fill_vpn,
    output logic [PFN_W-1:0] fill_pfn,
    output logic             fill_user,
    output logic             fill_writable,
    output logic             fill_dirty,
    output logic             fault_valid,
    output logic [EC_W-1:0]  fault_code,
    output logic [LA_W-1:0]  fault_addr
);
    localparam int N_DEC = 2;

    typedef struct packed {
        walk_st_e         st;
        logic [LA_W-1:0]  la;
        logic             wr;
        logic             usr;
        logic [LA_W-1:0]  pde;
        logic [LA_W-1:0]  maddr;
        logic             mwrite;
        logic [LA_W-1:0]  wdata;
        logic             fill_v;
        logic [PFN_W-1:0] fill_vpn;
        logic [PFN_W-1:0] fill_pfn;
        logic             fill_us;
        logic             fill_rw;
        logic             fill_dirty;
        logic             flt_v;
        logic [EC_W-1:0]  flt_code;
        logic [LA_W-1:0]  flt_addr;
    } regs_t;

    regs_t q, d;

    logic [LA_W-1:0] raw_in   [N_DEC];
    ent_t            ent_out  [N_DEC];
    logic [LA_W-1:0] upd_out  [N_DEC];
    logic            need_out [N_DEC];

    logic            eff_us, eff_rw, viol;
    logic            prot_sel;
    logic [EC_W-1:0] ecode;

    // slot 0 decodes the stored directory entry, slot 1 the entry on the port
    assign raw_in[0] = q.pde;
    assign raw_in[1] = (q.st == ST_UPD) ? q.wdata : mem_rsp_rdata;

    for (genvar g = 0; g < N_DEC; g++) begin : g_dec
        xw_entry_decode u_dec (
            .raw       (raw_in[g]),
            .is_write  (q.wr),
            .ent       (ent_out[g]),
            .upd_word  (upd_out[g]),
            .needs_upd (need_out[g])
        );
    end

    xw_perm_check u_perm (
        .dir_e    (ent_out[0]),
        .tbl_e    (ent_out[1]),
        .is_write (q.wr),
        .is_user  (q.usr),
        .eff_us   (eff_us),
        .eff_rw   (eff_rw),
        .viol     (viol)
    );

    assign prot_sel = (q.st == ST_TBL) && ent_out[1].present;

    xw_errcode #(.CODE_W(EC_W)) u_ec (
        .prot     (prot_sel),
        .is_write (q.wr),
        .is_user  (q.usr),
        .code     (ecode)
    );

    always_comb begin
        d        = q;
        d.fill_v = 1'b0;
        d.flt_v  = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (miss_valid) begin
                    d.st     = ST_DIR;
                    d.la     = miss_laddr;
                    d.wr     = miss_write;
                    d.usr    = miss_user;
                    d.mwrite = 1'b0;
                    d.maddr  = {dir_base[LA_W-1:OFF_W],
                                miss_laddr[LA_W-1 -: IDX_W],
                                {ENT_SH{1'b0}}};
                end
            end
            ST_DIR: begin
                if (mem_rsp_valid) begin
                    d.pde = mem_rsp_rdata;
                    if (!ent_out[1].present) begin
                        d.st       = ST_IDLE;
                        d.flt_v    = 1'b1;
                        d.flt_code = ecode;
                        d.flt_addr = q.la;
                    end else begin
                        d.st    = ST_TBL;
                        d.maddr = {ent_out[1].frame,
                                   q.la[OFF_W +: IDX_W],
                                   {ENT_SH{1'b0}}};
                    end
                end
            end
            ST_TBL: begin
                if (mem_rsp_valid) begin
                    if (!ent_out[1].present || viol) begin
                        d.st       = ST_IDLE;
                        d.flt_v    = 1'b1;
                        d.flt_code = ecode;
                        d.flt_addr = q.la;
                    end else if (need_out[1]) begin
                        d.st     = ST_UPD;
                        d.mwrite = 1'b1;
                        d.wdata  = upd_out[1];
                    end else begin
                        d.st         = ST_IDLE;
                        d.fill_v     = 1'b1;
                        d.fill_vpn   = q.la[LA_W-1:OFF_W];
                        d.fill_pfn   = ent_out[1].frame;
                        d.fill_us    = eff_us;
                        d.fill_rw    = eff_rw;
                        d.fill_dirty = ent_out[1].dirty;
                    end
                end
            end
            ST_UPD: begin
                if (mem_rsp_valid) begin
                    d.st         = ST_IDLE;
                    d.mwrite     = 1'b0;
                    d.fill_v     = 1'b1;
                    d.fill_vpn   = q.la[LA_W-1:OFF_W];
                    d.fill_pfn   = ent_out[1].frame;
                    d.fill_us    = eff_us;
                    d.fill_rw    = eff_rw;
                    d.fill_dirty = ent_out[1].dirty;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign miss_ready    = (q.st == ST_IDLE);
    assign mem_req_valid = (q.st != ST_IDLE);
    assign mem_req_write = q.mwrite;
    assign mem_req_addr  = q.maddr;
    assign mem_req_wdata = q.wdata;
    assign fill_valid    = q.fill_v;
    assign fill_vpn      = q.fill_vpn;
    assign fill_pfn      = q.fill_pfn;
    assign fill_user     = q.fill_us;
    assign fill_writable = q.fill_rw;
    assign fill_dirty    = q.fill_dirty;
    assign fault_valid   = q.flt_v;
    assign fault_code    = q.flt_code;
    assign fault_addr    = q.flt_addr;
endmodule

// File: rtl/xlat_walker_chk.sv
module xlat_walker_chk
    import xlat_walker_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            miss_ready,
    input logic            mem_req_valid,
    input logic            mem_req_write,
    input logic [LA_W-1:0] mem_req_addr,
    input logic            mem_rsp_valid,
    input logic            fill_valid,
    input logic            fault_valid,
    input logic [EC_W-1:0] fault_code,
    input logic [LA_W-1:0] fault_addr
);
    logic seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    // R10
    fill_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fill_valid && fault_valid));

    // R10
    fill_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> !fill_valid);

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_rsp_valid) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

    // R11
    idle_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss_ready |-> !mem_req_valid);

    // R2
    entry_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[ENT_SH-1:0] == '0));

    // R6
    code_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> (fault_code[EC_W-1:3] == '0));

    // R7
    faddr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !fault_valid) |-> $stable(fault_addr));
endmodule

bind xlat_walker xlat_walker_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .miss_ready    (miss_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .fill_valid    (fill_valid),
    .fault_valid   (fault_valid),
    .fault_code    (fault_code),
    .fault_addr    (fault_addr)
);

// File: tb/xlat_walker_tb.sv
module xlat_walker_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] BASE = 32'h0001_0000;

    logic        clk, rst_n;
    logic        miss_valid, miss_ready, miss_write, miss_user;
    logic [31:0] miss_laddr, dir_base;
    logic        mem_req_valid, mem_req_write, mem_rsp_valid;
    logic [31:0] mem_req_addr, mem_req_wdata, mem_rsp_rdata;
    logic        fill_valid, fill_user, fill_writable, fill_dirty, fault_valid;
    logic [19:0] fill_vpn, fill_pfn;
    logic [15:0] fault_code;
    logic [31:0] fault_addr;

    xlat_walker u_dut (.*);

    typedef struct {
        logic        is_fault;
        logic [15:0] code;
        logic [31:0] la;
        logic [19:0] pfn;
        logic        us, rw, dirty;
        logic [31:0] pde_a, pte_a, pte_after;
        int          rd, wr;
        string       rq;
    } exp_t;

    exp_t        sbq[$];
    logic [31:0] mem [int unsigned];
    logic [31:0] rd_log[$];
    int          n_wr, wr_base, lat_sel;
    int          n_checks, n_err;
    logic [31:0] last_fa;
    bit          done;

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] mrd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, expv);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    endtask

    function automatic exp_t predict(input logic [31:0] la, input logic wr, input logic usr);
        exp_t e;
        logic [31:0] pde, pte, upd;
        logic eus, erw;
        e = '{default: '0};
        e.la    = la;
        e.pde_a = {BASE[31:12], la[31:22], 2'b00};
        pde     = mrd(e.pde_a);
        e.rd    = 1;
        e.code  = {13'b0, usr, wr, 1'b0};
        if (!pde[0]) begin e.is_fault = 1; e.rq = "R3"; return e; end
        e.pte_a = {pde[31:12], la[21:12], 2'b00};
        pte     = mrd(e.pte_a);
        e.rd    = 2;
        e.pte_after = pte;
        if (!pte[0]) begin e.is_fault = 1; e.rq = "R4"; return e; end
        eus = pde[2] & pte[2];
        erw = pde[1] & pte[1];
        if (usr && (!eus || (wr && !erw))) begin
            e.is_fault = 1; e.code[0] = 1'b1; e.rq = "R5"; return e;
        end
        upd = pte | 32'h20 | (wr ? 32'h40 : 32'h0);
        e.pte_after = upd;
        e.wr    = (upd != pte) ? 1 : 0;
        e.pfn   = pte[31:12];
        e.us    = eus;
        e.rw    = erw;
        e.dirty = upd[6];
        e.rq    = "R9";
        return e;
    endfunction

    // memory model: one request at a time, latency cycles through 0..2
    initial begin
        mem_rsp_valid = 1'b0;
        mem_rsp_rdata = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (rst_n && mem_req_valid) begin
                repeat (lat_sel) @(negedge clk);
                lat_sel = (lat_sel + 1) % 3;
                if (mem_req_write) begin
                    mem[mem_req_addr] = mem_req_wdata;
                    n_wr++;
                end else begin
                    mem_rsp_rdata = mrd(mem_req_addr);
                    rd_log.push_back(mem_req_addr);
                end
                mem_rsp_valid = 1'b1;
            end
        end
    end

    // driver: predicts from the current tables, queues, then offers the miss
    task automatic walk(input logic [31:0] la, input logic wr, input logic usr);
        exp_t e;
        while (!miss_ready) @(negedge clk);
        e = predict(la, wr, usr);
        sbq.push_back(e);
        miss_valid = 1'b1;
        miss_laddr = la;
        miss_write = wr;
        miss_user  = usr;
        @(negedge clk);
        miss_valid = 1'b0;
        // R11: walker is busy once the miss is taken
        chk(miss_ready == 1'b0, "R11", "busy after accept", {31'b0, miss_ready}, 32'h0);
    endtask

    // monitor
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst_n && (fill_valid || fault_valid)) begin
                chk(!(fill_valid && fault_valid), "R10", "exclusive strobes",
                    {30'b0, fill_valid, fault_valid}, 32'h0);
                // R12: ready for a new miss while the strobe is shown
                chk(miss_ready == 1'b1, "R12", "ready during strobe", {31'b0, miss_ready}, 32'h1);
                if (sbq.size() == 0) begin
                    chk(1'b0, "R10", "unexpected strobe", 32'h1, 32'h0);
                end else begin
                    e = sbq.pop_front();
                    chk(fault_valid == e.is_fault, "R10", "result kind",
                        {31'b0, fault_valid}, {31'b0, e.is_fault});
                    chk(rd_log.size() == e.rd, "R3", "entry reads",
                        rd_log.size(), e.rd);
                    if (rd_log.size() > 0)
                        chk(rd_log[0] == e.pde_a, "R2", "directory address", rd_log[0], e.pde_a);
                    if (rd_log.size() > 1 && e.rd > 1)
                        chk(rd_log[1] == e.pte_a, "R2", "table address", rd_log[1], e.pte_a);
                    chk((n_wr - wr_base) == e.wr, "R8", "write-backs", n_wr - wr_base, e.wr);
                    if (e.rd > 1)
                        chk(mrd(e.pte_a) == e.pte_after, "R8", "entry after walk",
                            mrd(e.pte_a), e.pte_after);
                    if (e.is_fault) begin
                        chk(fault_code == e.code, e.rq, "fault code", {16'b0, fault_code}, {16'b0, e.code});
                        chk(fault_code[2:1] == e.code[2:1], "R6", "code direction/mode",
                            {30'b0, fault_code[2:1]}, {30'b0, e.code[2:1]});
                        chk(fault_addr == e.la, "R7", "fault address", fault_addr, e.la);
                        last_fa = e.la;
                    end else begin
                        chk(fill_vpn == e.la[31:12], "R9", "fill vpn", {12'b0, fill_vpn}, {12'b0, e.la[31:12]});
                        chk(fill_pfn == e.pfn, "R9", "fill pfn", {12'b0, fill_pfn}, {12'b0, e.pfn});
                        chk(fill_user == e.us && fill_writable == e.rw, "R5", "effective perms",
                            {30'b0, fill_user, fill_writable}, {30'b0, e.us, e.rw});
                        chk(fill_dirty == e.dirty, "R8", "fill dirty", {31'b0, fill_dirty}, {31'b0, e.dirty});
                        chk(fault_addr == last_fa, "R7", "fault address held", fault_addr, last_fa);
                    end
                end
                rd_log.delete();
                wr_base = n_wr;
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL R11 watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        n_checks = 0; n_err = 0; n_wr = 0; wr_base = 0; lat_sel = 0;
        last_fa = '0; done = 1'b0;
        rst_n = 1'b0; miss_valid = 1'b0; miss_laddr = '0;
        miss_write = 1'b0; miss_user = 1'b0; dir_base = BASE;

        // directory: idx1 user rw, idx2 absent, idx3 supervisor rw, idx4 user ro
        mem[BASE + 32'h4]  = 32'h0002_0007;
        mem[BASE + 32'h8]  = 32'h0000_0000;
        mem[BASE + 32'hC]  = 32'h0003_0003;
        mem[BASE + 32'h10] = 32'h0004_0005;
        // tables
        mem[32'h0002_0000] = 32'h0050_0007;
        mem[32'h0002_0004] = 32'h0000_0000;
        mem[32'h0002_0008] = 32'h0051_0067;
        mem[32'h0002_000C] = 32'h0052_0005;
        mem[32'h0003_0000] = 32'h0060_0007;
        mem[32'h0004_0000] = 32'h0070_0007;

        repeat (3) @(negedge clk);
        // R1
        chk(miss_ready == 1'b1, "R1", "ready after reset", {31'b0, miss_ready}, 32'h1);
        chk(!mem_req_valid && !fill_valid && !fault_valid, "R1", "quiet after reset",
            {29'b0, mem_req_valid, fill_valid, fault_valid}, 32'h0);
        chk(fault_addr == 32'h0, "R1", "fault address reset", fault_addr, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        walk(32'h0040_0123, 1'b0, 1'b1); // R8 accessed set on read
        walk(32'h0040_0456, 1'b1, 1'b1); // R8 dirty set on write
        walk(32'h0040_0789, 1'b1, 1'b1); // R8 no write-back, flags already set
        walk(32'h0040_1abc, 1'b0, 1'b1); // R4 absent table entry
        walk(32'h0080_0abc, 1'b1, 1'b0); // R3 absent directory entry
        walk(32'h0040_2010, 1'b1, 1'b1); // R8 A and D preset
        walk(32'h0040_3020, 1'b1, 1'b1); // R5 user write to read-only page
        walk(32'h0040_3020, 1'b1, 1'b0); // R5 supervisor write allowed
        walk(32'h00C0_0004, 1'b0, 1'b1); // R5 user on supervisor directory
        walk(32'h00C0_0008, 1'b0, 1'b0); // R5 supervisor read
        walk(32'h0100_0fff, 1'b1, 1'b1); // R5 read-only directory level
        walk(32'h0100_0ffc, 1'b0, 1'b1); // R9 user read through ro directory

        while (sbq.size() != 0) @(negedge clk);
        repeat (5) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule